// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block watches a bank of general-purpose input pins, split into groups of up to eight pins, and turns activity on them into interrupt requests. Every pin has its own trigger selection: a high or low level, a rising or falling edge, or either edge. A detected event latches a per-pin pending flag. Software reads and acknowledges these flags through a simple word-wide register port.

Per-group mask bits decide which pending flags may reach the single summary request that goes to the parent interrupt controller. A pin's pending flag is recorded whether it is masked or not. Unmasking a pin therefore raises the summary at once if an event was captured while the pin was blocked.

Pin inputs are asynchronous. Each one passes through a two-stage synchroniser before detection. Edges are found by comparing the synchronised value with its value one cycle earlier.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is asserted, every mask bit reads 1, every pending bit reads 0, every trigger field reads 0, and `irqOut` is low.
- R2: Trigger configuration words sit at byte address 0x700 + 4*g, mask words at 0x900 + 4*g, and pending words at 0xA00 + 4*g, for group g. Any other address reads 0. A mask word keeps only its low PINS_PER_GROUP bits, and the remaining bits read 0. A mask word changes only on a write to its own address.
- R3: The trigger field of pin p is bits [4p+2:4p] of its group's configuration word, and bit 4p+3 always reads 0. The codes are: 0 = level low, 1 = level high, 2 = falling edge, 3 = rising edge, 4 = either edge.
- R4: In an edge mode, a qualifying pin transition sets the pin's pending bit. The bit is visible from the third rising clock edge after the change.
- R5: In a level mode, the pending bit is set on every cycle in which the synchronised pin is at the active level. While the level lasts, an acknowledge write cannot clear the bit.
- R6: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R7: When an edge is detected in the same cycle as an acknowledge write of 1 to that bit, the bit stays set.
- R8: A pending bit is captured while its mask bit is 1. Setting the mask bit to 1 does not clear a pending bit.
- R9: `irqOut` is high exactly when some group has a bit that is pending and has its mask bit at 0. The groups are combined, so any group can raise it.
- R10: Trigger codes 5, 6 and 7 disable the pin, and no pin activity sets its pending bit.
- R11: A pending bit falls only on an acknowledge write of 1 to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_GROUPS*PINS_PER_GROUP | Asynchronous pin inputs. Bit g*PINS_PER_GROUP+p is pin p of group g |
| regWe | input | 1 | Register write strobe, sampled at the rising clock edge |
| regAddr | input | ADDR_W | Byte address for reads and writes |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Summary interrupt request |

## Verification
Two functions can act on the same pending bit in the same cycle: a freshly detected edge and a software acknowledge. The bench first leaves a rising-edge pin already pending. It then places the pin's rising transition so that detection lands on exactly the clock edge that samples a write-one acknowledge to that bit. The bench judges the outcome by reading the pending word afterwards, and expects the bit to remain set. A level input that is held active against a repeated acknowledge is judged the same way, by the pending word read after the write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int DATA_W = 32;

  // byte offsets of the three per-group register windows
  localparam int CFG_BASE  = 'h700;
  localparam int MASK_BASE = 'h900;
  localparam int PEND_BASE = 'hA00;

  // trigger codes; 5..7 leave a pin inert
  localparam logic [2:0] TRIG_LVL_LOW  = 3'd0;
  localparam logic [2:0] TRIG_LVL_HIGH = 3'd1;
  localparam logic [2:0] TRIG_FALL     = 3'd2;
  localparam logic [2:0] TRIG_RISE     = 3'd3;
  localparam logic [2:0] TRIG_BOTH     = 3'd4;

  // control -> datapath strobes
  typedef struct packed {
    logic cfgWr;
    logic maskWr;
    logic pendAck;
    logic cfgSel;
    logic maskSel;
    logic pendSel;
  } strobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 12,
  parameter int GRP_W      = 2
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobes,
  output logic [GRP_W-1:0]  grpIdx
);

  localparam int SPAN = 4 * NUM_GROUPS;

  logic [31:0] addr32;
  logic [31:0] cfgOff, maskOff, pendOff;
  logic        cfgHit, maskHit, pendHit;

  assign addr32  = 32'(regAddr);
  assign cfgOff  = addr32 - 32'(CFG_BASE);
  assign maskOff = addr32 - 32'(MASK_BASE);
  assign pendOff = addr32 - 32'(PEND_BASE);

  assign cfgHit  = (addr32 >= 32'(CFG_BASE))  && (cfgOff  < 32'(SPAN));
  assign maskHit = (addr32 >= 32'(MASK_BASE)) && (maskOff < 32'(SPAN));
  assign pendHit = (addr32 >= 32'(PEND_BASE)) && (pendOff < 32'(SPAN));

  always_comb begin
    grpIdx = '0;
    if (cfgHit)       grpIdx = cfgOff[GRP_W+1:2];
    else if (maskHit) grpIdx = maskOff[GRP_W+1:2];
    else if (pendHit) grpIdx = pendOff[GRP_W+1:2];
  end

  always_comb begin
    strobes         = '0;
    strobes.cfgSel  = cfgHit;
    strobes.maskSel = maskHit;
    strobes.pendSel = pendHit;
    strobes.cfgWr   = regWe && cfgHit;
    strobes.maskWr  = regWe && maskHit;
    strobes.pendAck = regWe && pendHit;
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_GROUPS     = 4,
  parameter int PINS_PER_GROUP = 8,
  parameter int GRP_W          = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] pinIn,
  input  strobe_t                              strobes,
  input  logic [GRP_W-1:0]                     grpIdx,
  input  logic [DATA_W-1:0]                    wdata,
  output logic [DATA_W-1:0]                    rdata,
  output logic [NUM_GROUPS*PINS_PER_GROUP-1:0] pendAll,
  output logic [NUM_GROUPS*PINS_PER_GROUP-1:0] maskAll,
  output logic                                 irqOut
);

  localparam int P     = PINS_PER_GROUP;
  localparam int NPINS = NUM_GROUPS * P;

  logic [NPINS-1:0]   syncA, syncB, prevQ;
  logic [3*NPINS-1:0] cfgFlat;
  logic [NPINS-1:0]   hitVec, ackVec, pendNext;

  // two-stage synchroniser plus one history stage for edge compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  // per-pin trigger decode
  for (genvar i = 0; i < NPINS; i++) begin : g_detect
    logic [2:0] mode;
    logic       cur, old;
    assign mode = cfgFlat[i*3 +: 3];
    assign cur  = syncB[i];
    assign old  = prevQ[i];
    always_comb begin
      unique case (mode)
        TRIG_LVL_LOW:  hitVec[i] = !cur;
        TRIG_LVL_HIGH: hitVec[i] = cur;
        TRIG_FALL:     hitVec[i] = old && !cur;
        TRIG_RISE:     hitVec[i] = !old && cur;
        TRIG_BOTH:     hitVec[i] = old ^ cur;
        default:       hitVec[i] = 1'b0;
      endcase
    end
  end

  // write-one acknowledge vector for the addressed group
  always_comb begin
    ackVec = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (strobes.pendAck && (grpIdx == GRP_W'(g)))
        ackVec[g*P +: P] = wdata[P-1:0];
    end
  end

  // a detection in the same cycle as an acknowledge keeps the bit set
  assign pendNext = (pendAll & ~ackVec) | hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgFlat <= '0;
      maskAll <= '1;
      pendAll <= '0;
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (strobes.cfgWr && (grpIdx == GRP_W'(g))) begin
          for (int p = 0; p < P; p++)
            cfgFlat[(g*P+p)*3 +: 3] <= wdata[p*4 +: 3];
        end
        if (strobes.maskWr && (grpIdx == GRP_W'(g)))
          maskAll[g*P +: P] <= wdata[P-1:0];
      end
      pendAll <= pendNext;
    end
  end

  // read mux; nibble bit 3 and unused upper bits stay zero
  always_comb begin
    rdata = '0;
    if (strobes.cfgSel) begin
      for (int p = 0; p < P; p++)
        rdata[p*4 +: 3] = cfgFlat[(int'(grpIdx)*P+p)*3 +: 3];
    end else if (strobes.maskSel) begin
      rdata[P-1:0] = maskAll[int'(grpIdx)*P +: P];
    end else if (strobes.pendSel) begin
      rdata[P-1:0] = pendAll[int'(grpIdx)*P +: P];
    end
  end

  assign irqOut = |(pendAll & ~maskAll);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_GROUPS     = 4,
  parameter int PINS_PER_GROUP = 8,
  parameter int ADDR_W         = 12
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] pinIn,
  input  logic                                 regWe,
  input  logic [ADDR_W-1:0]                    regAddr,
  input  logic [31:0]                          regWdata,
  output logic [31:0]                          regRdata,
  output logic                                 irqOut
);

  localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int NPINS = NUM_GROUPS * PINS_PER_GROUP;

  strobe_t          strobes;
  logic [GRP_W-1:0] grpIdx;
  logic [NPINS-1:0] pendAll, maskAll;

  gpio_irq_ctrl #(
    .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W), .GRP_W(GRP_W)
  ) ctrl_i (
    .regWe  (regWe),
    .regAddr(regAddr),
    .strobes(strobes),
    .grpIdx (grpIdx)
  );

  gpio_irq_datapath #(
    .NUM_GROUPS(NUM_GROUPS), .PINS_PER_GROUP(PINS_PER_GROUP), .GRP_W(GRP_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .strobes(strobes),
    .grpIdx (grpIdx),
    .wdata  (regWdata),
    .rdata  (regRdata),
    .pendAll(pendAll),
    .maskAll(maskAll),
    .irqOut (irqOut)
  );

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NUM_GROUPS     = 4,
  parameter int PINS_PER_GROUP = 8,
  parameter int ADDR_W         = 12
) (
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 regWe,
  input logic [ADDR_W-1:0]                    regAddr,
  input logic [31:0]                          regWdata,
  input logic [NUM_GROUPS*PINS_PER_GROUP-1:0] pendAll,
  input logic [NUM_GROUPS*PINS_PER_GROUP-1:0] maskAll,
  input logic                                 irqOut
);

  localparam int SPAN = 4 * NUM_GROUPS;

  logic [31:0] a32;
  logic        pendWinWr, maskWinWr;

  assign a32       = 32'(regAddr);
  assign pendWinWr = regWe && (a32 >= 32'('hA00)) && (a32 < 32'('hA00 + SPAN));
  assign maskWinWr = regWe && (a32 >= 32'('h900)) && (a32 < 32'('h900 + SPAN));

  // R11: no pending bit falls without an acknowledge write
  assert_no_stray_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    !pendWinWr |=> (($past(pendAll) & ~pendAll) == '0));

  // R6: a pending write of all zeros clears nothing
  assert_zero_ack_inert_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pendWinWr && (regWdata[PINS_PER_GROUP-1:0] == '0)) |=>
      (($past(pendAll) & ~pendAll) == '0));

  // R2: mask state moves only on a write inside the mask window
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !maskWinWr |=> $stable(maskAll));

  // R9: a fully masked bank keeps the summary low
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (&maskAll) |-> !irqOut);

  // R9: the summary is never raised with nothing pending
  assert_irq_needs_pend_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (pendAll != '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NUM_GROUPS(NUM_GROUPS), .PINS_PER_GROUP(PINS_PER_GROUP), .ADDR_W(ADDR_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .regWe   (regWe),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .pendAll (pendAll),
  .maskAll (maskAll),
  .irqOut  (irqOut)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;

  localparam int G = 4;
  localparam int P = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [G*P-1:0] pinIn = '1;
  logic          regWe = 1'b0;
  logic [11:0]   regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic          irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.NUM_GROUPS(G), .PINS_PER_GROUP(P), .ADDR_W(12)) dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t expQ[$];
  event  chkEv;

  function automatic logic [11:0] cfgA(int g);  return 12'(32'h700 + g*4); endfunction
  function automatic logic [11:0] maskA(int g); return 12'(32'h900 + g*4); endfunction
  function automatic logic [11:0] pendA(int g); return 12'(32'hA00 + g*4); endfunction

  // monitor: pops expectations and compares away from the clock edge
  initial begin
    forever begin
      @(chkEv);
      #1;
      while (expQ.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = expQ.pop_front();
        got = it.isIrq ? {31'b0, irqOut} : regRdata;
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic expRd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    regAddr = a;
    it.isIrq = 0; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    ->chkEv;
  endtask

  task automatic expIrq(input bit e, input string tag);
    item_t it;
    @(negedge clk);
    it.isIrq = 1; it.exp = {31'b0, e}; it.tag = tag;
    expQ.push_back(it);
    ->chkEv;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPin(input int idx, input logic v);
    @(negedge clk);
    pinIn[idx] = v;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    idle(2);
    // R1: reset state while reset is held
    expRd(maskA(0), 32'h0000_00FF, "R1 mask g0 at reset");
    expRd(maskA(3), 32'h0000_00FF, "R1 mask g3 at reset");
    expRd(pendA(0), 32'h0, "R1 pend g0 at reset");
    expRd(cfgA(2), 32'h0, "R1 cfg g2 at reset");
    expIrq(1'b0, "R1 irq at reset");
    @(negedge clk);
    rstN = 1'b1;

    // disable every pin, then drop the level-low captures of the first cycles
    for (int g = 0; g < G; g++) wr(cfgA(g), 32'h7777_7777);
    idle(4);
    for (int g = 0; g < G; g++) wr(pendA(g), 32'hFF);
    expRd(pendA(1), 32'h0, "R6 pend g1 cleared");

    // R3: bit 3 of each nibble reads zero
    wr(cfgA(1), 32'hFFFF_FFFF);
    expRd(cfgA(1), 32'h7777_7777, "R3 nibble bit3 zero");
    wr(cfgA(1), 32'h7777_7777);

    // R2: mask width and unmapped addresses
    wr(maskA(3), 32'hFFFF_FF0F);
    expRd(maskA(3), 32'h0000_000F, "R2 mask upper bits");
    wr(maskA(3), 32'hFF);
    expRd(12'h800, 32'h0, "R2 unmapped gap");
    expRd(12'h710, 32'h0, "R2 group beyond bank");

    // R10: disabled pin ignores toggles
    setPin(0, 1'b0); idle(4); setPin(0, 1'b1); idle(4);
    expRd(pendA(0), 32'h0, "R10 disabled pin");

    // R4: rising edge on g0 pin0
    wr(cfgA(0), 32'h7777_7773);
    setPin(0, 1'b0); idle(4);
    expRd(pendA(0), 32'h0, "R4 falling ignored in rise mode");
    setPin(0, 1'b1); idle(4);
    expRd(pendA(0), 32'h01, "R4 rising captured");
    expIrq(1'b0, "R8 masked pend no irq");
    wr(maskA(0), 32'hFE);
    expIrq(1'b1, "R9 unmask raises irq");
    wr(pendA(0), 32'h01);
    expRd(pendA(0), 32'h0, "R6 ack clears");
    expIrq(1'b0, "R9 irq drops after ack");

    // R4 latency: visible after third edge, not before
    setPin(0, 1'b0); idle(3);
    @(negedge clk); pinIn[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    checks++;
    if (irqOut !== 1'b0) begin fails++; $display("FAIL R4 early: got %b expected 0", irqOut); end
    @(posedge clk); #1;
    checks++;
    if (irqOut !== 1'b1) begin fails++; $display("FAIL R4 third edge: got %b expected 1", irqOut); end
    wr(pendA(0), 32'h01);
    wr(maskA(0), 32'hFF);

    // falling edge on pin1, zero write inert
    wr(cfgA(0), 32'h7777_7723);
    setPin(1, 1'b0); idle(4);
    expRd(pendA(0), 32'h02, "R4 falling captured");
    wr(pendA(0), 32'h00);
    expRd(pendA(0), 32'h02, "R6 zero write no effect");
    wr(pendA(0), 32'h02);
    setPin(1, 1'b1); idle(4);

    // both edges on pin2
    wr(cfgA(0), 32'h7777_7423);
    setPin(2, 1'b0); idle(4);
    expRd(pendA(0), 32'h04, "R4 both mode fall");
    wr(pendA(0), 32'h04);
    setPin(2, 1'b1); idle(4);
    expRd(pendA(0), 32'h04, "R4 both mode rise");
    wr(pendA(0), 32'h04);
    expRd(pendA(0), 32'h0, "R6 both cleared");

    // R5: level high on g2 pin5 resists ack
    wr(cfgA(2), 32'h7717_7777);
    idle(2);
    expRd(pendA(2), 32'h20, "R5 level high captured");
    wr(pendA(2), 32'h20);
    expRd(pendA(2), 32'h20, "R5 ack while level active");
    setPin(21, 1'b0); idle(4);
    wr(pendA(2), 32'h20);
    expRd(pendA(2), 32'h0, "R5 ack after level gone");

    // level low plus summary across groups
    wr(cfgA(2), 32'h7707_7777);
    idle(2);
    expRd(pendA(2), 32'h20, "R5 level low captured");
    wr(maskA(2), 32'hDF);
    expIrq(1'b1, "R9 irq from group 2");
    wr(maskA(2), 32'hFF);
    expIrq(1'b0, "R8 remask lowers irq");
    expRd(pendA(2), 32'h20, "R8 pend kept under mask");
    setPin(21, 1'b1); idle(4);
    wr(pendA(2), 32'h20);
    expRd(pendA(2), 32'h0, "R6 level low cleared");

    // R7: edge and acknowledge on the same clock edge
    wr(cfgA(3), 32'h7777_7773);
    setPin(24, 1'b0); idle(4);
    setPin(24, 1'b1); idle(4);
    expRd(pendA(3), 32'h01, "R4 g3 rising captured");
    setPin(24, 1'b0); idle(4);
    @(negedge clk); pinIn[24] = 1'b1;
    @(negedge clk);
    @(negedge clk); regWe = 1'b1; regAddr = pendA(3); regWdata = 32'h01;
    @(negedge clk); regWe = 1'b0;
    expRd(pendA(3), 32'h01, "R7 edge beats ack");
    wr(pendA(3), 32'h01);
    expRd(pendA(3), 32'h0, "R7 later ack clears");

    idle(2);
    done = 1;
    summary();
    $finish;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule